// File: doc/BRIEF.md
# Two-Step Transmit Timestamp Queue

This block collects egress timestamps for frames whose precise departure time has to be reported afterwards in a follow-up message. The egress path pushes a transmit record for each such frame. That record holds the egress port, the nanosecond part of the departure time, a sub-nanosecond byte and the frame's 16-bit identifier. The block stores the record as two adjacent queue entries. The receive path may also push single-entry receive stamps into the same queue.

A CPU drains the queue through a small register view. A status word carries a valid flag, a sticky overflow flag, a transmit flag and the egress port of the head entry. A stamp field and a sub-nanosecond field carry the head entry's payload. A "next" strobe pops the head. For a transmit record, the first entry shows the nanosecond stamp. The entry after it shows the identifier, with its upper bits in the stamp field and its low byte in the sub-nanosecond field. Software matches that identifier against the frames it has sent, typically counting identifiers 0 to 511 and wrapping. The interrupt line is high whenever the queue holds an entry, so a drain loop runs until valid reads 0.

The overflow flag is kept by a two-state machine. In state OVF_CLEAR it moves to OVF_FLAGGED when a push is dropped. In OVF_FLAGGED it returns to OVF_CLEAR when the CPU writes the clear strobe in a cycle with no drop. Otherwise each state holds.

Top module: `ts_twostep_fifo`

## Requirements
- R1: After reset, st_valid, st_ovf, st_is_tx, st_port, rd_stamp, rd_subns and irq are all 0.
- R2: A transmit record is stored as two adjacent entries. The first has st_is_tx=1, the record's port, rd_stamp = nanoseconds and rd_subns = the sub-ns byte. The second has st_is_tx=1, the same port, rd_stamp = identifier bits [15:8] zero-extended and rd_subns = identifier bits [7:0]. For example, identifier 511 reads as stamp 1 and sub 0xFF.
- R3: A receive push is stored as one entry with st_is_tx=0, its port, its nanoseconds in rd_stamp and its sub-ns byte in rd_subns.
- R4: Entries leave in arrival order. A cpu_next pulse exposes the following entry one cycle later. A cpu_next pulse on an empty queue has no effect.
- R5: When a receive push and a transmit record arrive in the same cycle, the receive entry is queued ahead of both record entries.
- R6: A transmit record that finds fewer than two free slots is dropped whole: neither of its entries is stored. The stored entries are unchanged, and st_ovf goes to 1.
- R7: A receive push that finds no free slot is dropped and st_ovf goes to 1.
- R8: st_ovf stays 1 until a cpu_ovf_clr pulse clears it. If a drop happens in the same cycle as the clear, st_ovf stays 1.
- R9: irq is 1 exactly while st_valid is 1.
- R10: Free space is judged on the occupancy before any pop in the same cycle. A record pushed into a queue with one free slot while a pop happens is still dropped.
- R11: The queue holds exactly DEPTH entries (16 by default), so DEPTH/2 records fit without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_push | input | 1 | Push one transmit record (two entries) |
| tx_port | input | PORT_W | Egress port of the record |
| tx_nsec | input | NS_W | Nanoseconds of the egress time |
| tx_subns | input | SUB_W | Sub-nanosecond byte of the egress time |
| tx_fid | input | FID_W | Frame identifier |
| rx_push | input | 1 | Push one receive stamp entry |
| rx_port | input | PORT_W | Ingress port of the receive stamp |
| rx_nsec | input | NS_W | Nanoseconds of the receive stamp |
| rx_subns | input | SUB_W | Sub-nanosecond byte of the receive stamp |
| cpu_next | input | 1 | Pop the head entry |
| cpu_ovf_clr | input | 1 | Write-one strobe that clears the overflow flag |
| st_valid | output | 1 | Head entry present |
| st_ovf | output | 1 | Sticky overflow flag |
| st_is_tx | output | 1 | Head entry belongs to a transmit record |
| st_port | output | PORT_W | Port of the head entry |
| rd_stamp | output | NS_W | Stamp field of the head entry |
| rd_subns | output | SUB_W | Sub-ns field of the head entry |
| irq | output | 1 | Interrupt, high while st_valid is 1 |

## Verification
A corrupted read or write pointer shows up at the ports on the next pop. The head then displays a stamp, identifier or port out of order, or the identifier half of a record appears without its stamp half. A wrong occupancy count shows within one drain: the number of entries popped before st_valid falls differs from the number of pushes accepted. It also shows as an overflow flagged too early or too late at the full boundary. A faulty overflow state machine is visible in the cycle after the drop or clear strobe.

// File: rtl/ts_fifo_pkg.sv
package ts_fifo_pkg;

    // Kind of a stored entry; the two kinds of a transmit record are adjacent.
    typedef enum logic [1:0] {
        K_RX_STAMP = 2'd0,
        K_TX_STAMP = 2'd1,
        K_TX_ID    = 2'd2
    } ent_kind_t;

    // Sticky overflow state.
    typedef enum logic {
        OVF_CLEAR   = 1'b0,
        OVF_FLAGGED = 1'b1
    } ovf_state_t;

    // Largest number of entries written in one cycle (receive + record).
    localparam int unsigned MAX_WRITES = 3;

endpackage

// File: rtl/ts_fifo_admit.sv
module ts_fifo_admit
    import ts_fifo_pkg::*;
#(
    parameter type ent_t = logic,
    parameter int  DEPTH = 16,
    parameter int  CNT_W = 5
) (
    input  logic             rx_req,
    input  logic             tx_req,
    input  logic [CNT_W-1:0] occupancy,
    input  ent_t             rx_ent,
    input  ent_t             tx_stamp_ent,
    input  ent_t             tx_id_ent,
    output logic [1:0]       wr_cnt,
    output ent_t             wr_ent [MAX_WRITES],
    output logic             drop
);

    logic [CNT_W-1:0] free_now;
    logic [CNT_W-1:0] free_after_rx;
    logic             rx_ok;
    logic             tx_ok;

    // Space is judged on occupancy before any pop of this cycle.
    always_comb begin
        free_now      = CNT_W'(DEPTH) - occupancy;
        rx_ok         = rx_req && (free_now != '0);
        free_after_rx = free_now - CNT_W'(rx_ok);
        tx_ok         = tx_req && (free_after_rx >= CNT_W'(2));
        wr_cnt        = 2'(rx_ok) + (tx_ok ? 2'd2 : 2'd0);
        drop          = (rx_req && !rx_ok) || (tx_req && !tx_ok);
    end

    // Receive entry first, then the two record entries.
    always_comb begin
        wr_ent[0] = rx_ok ? rx_ent       : tx_stamp_ent;
        wr_ent[1] = rx_ok ? tx_stamp_ent : tx_id_ent;
        wr_ent[2] = tx_id_ent;
    end

endmodule

// File: rtl/ts_fifo_store.sv
module ts_fifo_store
    import ts_fifo_pkg::*;
#(
    parameter type ent_t = logic,
    parameter int  DEPTH = 16,
    parameter int  PTR_W = $clog2(DEPTH),
    parameter int  CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       wr_cnt,
    input  ent_t             wr_ent [MAX_WRITES],
    input  logic             pop,
    output ent_t             head,
    output logic [CNT_W-1:0] occupancy
);

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] occ_q;
    logic             pop_eff;
    ent_t             slots [DEPTH];

    assign pop_eff   = pop && (occ_q != '0);
    assign occupancy = occ_q;
    assign head      = slots[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ_q  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(wr_cnt);
            rd_ptr <= rd_ptr + PTR_W'(pop_eff);
            occ_q  <= occ_q + CNT_W'(wr_cnt) - CNT_W'(pop_eff);
        end
    end

    // Each slot picks its write lane from its distance to the write pointer.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic [PTR_W-1:0] off;
        logic             hit;
        ent_t             slot_q;

        assign off = PTR_W'(s) - wr_ptr;
        assign hit = off < PTR_W'(wr_cnt);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (hit) begin
                slot_q <= wr_ent[off[1:0]];
            end
        end

        assign slots[s] = slot_q;
    end

endmodule

// File: rtl/ts_fifo_ovf.sv
module ts_fifo_ovf
    import ts_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic drop,
    input  logic clr,
    output logic flag
);

    ovf_state_t state_q;
    ovf_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVF_CLEAR:   if (drop)         state_d = OVF_FLAGGED;
            OVF_FLAGGED: if (clr && !drop) state_d = OVF_CLEAR;
            default:                       state_d = OVF_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OVF_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == OVF_FLAGGED);
    end

endmodule

// File: rtl/ts_twostep_fifo.sv
module ts_twostep_fifo
    import ts_fifo_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int PORT_W = 7,
    parameter int NS_W   = 30,
    parameter int SUB_W  = 8,
    parameter int FID_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_push,
    input  logic [PORT_W-1:0] tx_port,
    input  logic [NS_W-1:0]   tx_nsec,
    input  logic [SUB_W-1:0]  tx_subns,
    input  logic [FID_W-1:0]  tx_fid,
    input  logic              rx_push,
    input  logic [PORT_W-1:0] rx_port,
    input  logic [NS_W-1:0]   rx_nsec,
    input  logic [SUB_W-1:0]  rx_subns,
    input  logic              cpu_next,
    input  logic              cpu_ovf_clr,
    output logic              st_valid,
    output logic              st_ovf,
    output logic              st_is_tx,
    output logic [PORT_W-1:0] st_port,
    output logic [NS_W-1:0]   rd_stamp,
    output logic [SUB_W-1:0]  rd_subns,
    output logic              irq
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        ent_kind_t         kind;
        logic [PORT_W-1:0] port;
        logic [NS_W-1:0]   stamp;
        logic [SUB_W-1:0]  sub;
    } entry_t;

    entry_t           rx_ent;
    entry_t           tx_stamp_ent;
    entry_t           tx_id_ent;
    entry_t           head_ent;
    entry_t           wr_ent [MAX_WRITES];
    logic [1:0]       wr_cnt;
    logic             rec_drop;
    logic [CNT_W-1:0] occ;
    logic             head_is_stamp;
    logic             head_is_id;

    // Entry formatting: identifier splits into upper bits and a low byte.
    always_comb begin
        rx_ent       = '{kind: K_RX_STAMP, port: rx_port, stamp: rx_nsec, sub: rx_subns};
        tx_stamp_ent = '{kind: K_TX_STAMP, port: tx_port, stamp: tx_nsec, sub: tx_subns};
        tx_id_ent    = '{kind:  K_TX_ID,
                         port:  tx_port,
                         stamp: NS_W'(tx_fid[FID_W-1:SUB_W]),
                         sub:   tx_fid[SUB_W-1:0]};
    end

    ts_fifo_admit #(
        .ent_t (entry_t),
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_admit (
        .rx_req       (rx_push),
        .tx_req       (tx_push),
        .occupancy    (occ),
        .rx_ent       (rx_ent),
        .tx_stamp_ent (tx_stamp_ent),
        .tx_id_ent    (tx_id_ent),
        .wr_cnt       (wr_cnt),
        .wr_ent       (wr_ent),
        .drop         (rec_drop)
    );

    ts_fifo_store #(
        .ent_t (entry_t),
        .DEPTH (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cnt    (wr_cnt),
        .wr_ent    (wr_ent),
        .pop       (cpu_next),
        .head      (head_ent),
        .occupancy (occ)
    );

    ts_fifo_ovf u_ovf (
        .clk   (clk),
        .rst_n (rst_n),
        .drop  (rec_drop),
        .clr   (cpu_ovf_clr),
        .flag  (st_ovf)
    );

    // Register view of the head entry, zero while empty.
    always_comb begin
        st_valid      = (occ != '0);
        st_is_tx      = st_valid && (head_ent.kind != K_RX_STAMP);
        st_port       = st_valid ? head_ent.port  : '0;
        rd_stamp      = st_valid ? head_ent.stamp : '0;
        rd_subns      = st_valid ? head_ent.sub   : '0;
        irq           = st_valid;
        head_is_stamp = st_valid && (head_ent.kind == K_TX_STAMP);
        head_is_id    = st_valid && (head_ent.kind == K_TX_ID);
    end

endmodule

// File: rtl/ts_twostep_fifo_chk.sv
module ts_twostep_fifo_chk #(
    parameter int CNT_W = 5,
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_push,
    input logic             rx_push,
    input logic             cpu_next,
    input logic             cpu_ovf_clr,
    input logic             st_valid,
    input logic             st_ovf,
    input logic             head_is_stamp,
    input logic             head_is_id,
    input logic             rec_drop,
    input logic [CNT_W-1:0] occ
);

    assert_id_follows_stamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        head_is_stamp && cpu_next |=> head_is_id);

    assert_empty_pop_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid && !tx_push && !rx_push |=> !st_valid);

    assert_drop_sets_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rec_drop |=> st_ovf);

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_ovf && !cpu_ovf_clr |=> st_ovf);

    assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ovf_clr && !rec_drop |=> !st_ovf);

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

endmodule

bind ts_twostep_fifo ts_twostep_fifo_chk #(
    .CNT_W (CNT_W),
    .DEPTH (DEPTH)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_push       (tx_push),
    .rx_push       (rx_push),
    .cpu_next      (cpu_next),
    .cpu_ovf_clr   (cpu_ovf_clr),
    .st_valid      (st_valid),
    .st_ovf        (st_ovf),
    .head_is_stamp (head_is_stamp),
    .head_is_id    (head_is_id),
    .rec_drop      (rec_drop),
    .occ           (occ)
);

// File: tb/ts_twostep_fifo_test.sv
`timescale 1ns/1ps
module ts_twostep_fifo_test;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_push = 1'b0;
    logic [6:0]  tx_port = '0;
    logic [29:0] tx_nsec = '0;
    logic [7:0]  tx_subns = '0;
    logic [15:0] tx_fid = '0;
    logic        rx_push = 1'b0;
    logic [6:0]  rx_port = '0;
    logic [29:0] rx_nsec = '0;
    logic [7:0]  rx_subns = '0;
    logic        cpu_next = 1'b0;
    logic        cpu_ovf_clr = 1'b0;
    logic        st_valid, st_ovf, st_is_tx, irq;
    logic [6:0]  st_port;
    logic [29:0] rd_stamp;
    logic [7:0]  rd_subns;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ts_twostep_fifo uut (
        .clk(clk), .rst_n(rst_n),
        .tx_push(tx_push), .tx_port(tx_port), .tx_nsec(tx_nsec),
        .tx_subns(tx_subns), .tx_fid(tx_fid),
        .rx_push(rx_push), .rx_port(rx_port), .rx_nsec(rx_nsec), .rx_subns(rx_subns),
        .cpu_next(cpu_next), .cpu_ovf_clr(cpu_ovf_clr),
        .st_valid(st_valid), .st_ovf(st_ovf), .st_is_tx(st_is_tx), .st_port(st_port),
        .rd_stamp(rd_stamp), .rd_subns(rd_subns), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic head_is(input string req, input bit tx, input int port,
                           input int stamp, input int sub);
        check(req, "valid", 32'(st_valid), 1);
        check(req, "irq", 32'(irq), 1);
        check(req, "is_tx", 32'(st_is_tx), 32'(tx));
        check(req, "port", 32'(st_port), port);
        check(req, "stamp", 32'(rd_stamp), stamp);
        check(req, "subns", 32'(rd_subns), sub);
    endtask

    task automatic push_rec(input int port, input int nsec, input int sub, input int fid);
        tx_port = 7'(port); tx_nsec = 30'(nsec); tx_subns = 8'(sub); tx_fid = 16'(fid);
        tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic push_rx(input int port, input int nsec, input int sub);
        rx_port = 7'(port); rx_nsec = 30'(nsec); rx_subns = 8'(sub);
        rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic pop();
        cpu_next = 1'b1;
        @(negedge clk);
        cpu_next = 1'b0;
    endtask

    task automatic clear_ovf();
        cpu_ovf_clr = 1'b1;
        @(negedge clk);
        cpu_ovf_clr = 1'b0;
    endtask

    task automatic drain(output int n, output int last);
        n = 0; last = -1;
        while (st_valid && n < 40) begin
            last = int'(rd_stamp);
            pop();
            n++;
        end
    endtask

    task automatic t_reset();
        check("R1", "valid", 32'(st_valid), 0);
        check("R1", "ovf", 32'(st_ovf), 0);
        check("R1", "irq", 32'(irq), 0);
        check("R1", "fields", {st_is_tx, st_port, rd_stamp[15:0], rd_subns}, 0);
    endtask

    task automatic t_record();
        push_rec(5, 123456789, 8'h3C, 511);
        head_is("R2 R9", 1, 5, 123456789, 8'h3C);
        pop();
        head_is("R2", 1, 5, 1, 8'hFF);
        pop();
        check("R9", "irq empty", 32'(irq), 0);
        push_rec(3, 42, 1, 16'h1234);
        pop();
        head_is("R2", 1, 3, 16'h12, 16'h34);
        pop();
        push_rec(9, 7, 2, 256);
        pop();
        head_is("R2", 1, 9, 1, 0);
        pop();
    endtask

    task automatic t_rx();
        push_rx(2, 999, 7);
        head_is("R3", 0, 2, 999, 7);
        pop();
        check("R3", "empty", 32'(st_valid), 0);
    endtask

    task automatic t_order_empty();
        pop();
        check("R4", "empty pop", 32'(st_valid), 0);
        push_rx(1, 11, 1);
        push_rec(4, 22, 2, 16'h0305);
        push_rx(6, 33, 3);
        head_is("R4", 0, 1, 11, 1);
        pop();
        head_is("R4", 1, 4, 22, 2);
        pop();
        head_is("R4", 1, 4, 3, 5);
        pop();
        head_is("R4", 0, 6, 33, 3);
        pop();
        check("R4", "drained", 32'(st_valid), 0);
    endtask

    task automatic t_same_cycle();
        rx_port = 7'd8; rx_nsec = 30'd500; rx_subns = 8'd9;
        tx_port = 7'd12; tx_nsec = 30'd600; tx_subns = 8'd4; tx_fid = 16'h0210;
        rx_push = 1'b1; tx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0; tx_push = 1'b0;
        head_is("R5", 0, 8, 500, 9);
        pop();
        head_is("R5", 1, 12, 600, 4);
        pop();
        head_is("R5", 1, 12, 2, 16'h10);
        pop();
        check("R5", "drained", 32'(st_valid), 0);
    endtask

    task automatic t_overflow();
        int n, last;
        for (int i = 0; i < 7; i++) push_rec(i, 100 + i, 0, i);
        push_rx(0, 1000, 0);
        check("R6", "no ovf at 15", 32'(st_ovf), 0);
        push_rec(1, 777, 0, 1);
        check("R6", "ovf set", 32'(st_ovf), 1);
        head_is("R6", 1, 0, 100, 0);
        push_rx(0, 2000, 0);
        check("R8", "ovf sticky", 32'(st_ovf), 1);
        rx_port = '0; rx_nsec = 30'd3000; rx_subns = '0;
        rx_push = 1'b1; cpu_ovf_clr = 1'b1;
        @(negedge clk);
        rx_push = 1'b0; cpu_ovf_clr = 1'b0;
        check("R8", "set beats clear", 32'(st_ovf), 1);
        clear_ovf();
        check("R8", "cleared", 32'(st_ovf), 0);
        drain(n, last);
        check("R6 R7", "entries kept", n, 16);
        check("R7", "last entry", last, 2000);
    endtask

    task automatic t_pop_push();
        int n, last;
        for (int i = 0; i < 7; i++) push_rec(i, 200 + i, 0, i);
        push_rx(0, 50, 0);
        tx_port = '0; tx_nsec = 30'd888; tx_subns = '0; tx_fid = '0;
        tx_push = 1'b1; cpu_next = 1'b1;
        @(negedge clk);
        tx_push = 1'b0; cpu_next = 1'b0;
        check("R10", "ovf on pop+push", 32'(st_ovf), 1);
        clear_ovf();
        drain(n, last);
        check("R10", "entries left", n, 14);
        check("R10", "last entry", last, 50);
    endtask

    task automatic t_capacity();
        int n, last;
        for (int i = 0; i < 8; i++) push_rec(i, 300 + i, 0, 16'h0700 + i);
        check("R11", "no ovf when full", 32'(st_ovf), 0);
        drain(n, last);
        check("R11", "capacity", n, DEPTH);
        check("R11", "last id upper", last, 7);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_record();
        t_rx();
        t_order_empty();
        t_same_cycle();
        t_overflow();
        t_pop_push();
        t_capacity();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            report();
        end
    end

endmodule